// File: doc/BRIEF.md
# Optical Cage Status Monitor

This block watches the three slow status pins of a pluggable optical module cage. The pins report receive signal loss, transmit fault and module absence. Each pin can change at any time with respect to the system clock, so each one passes through a synchroniser chain before it is used. The block then presents a six-bit status word. The low half holds the present level of each pin. The high half holds one sticky flag per pin, and that flag remembers that the pin changed at some point since the last time the word was read.

A processor polls the word and raises a one-cycle read strobe at the moment it samples the word. That same strobe clears the sticky flags on the next clock edge. A change that lands on the clearing edge is not lost. The OR of the three flags is also brought out as an interrupt line, so polling can be replaced by an event.

Software uses the word as follows. A change flag on the module-absent bit, with that bit now low, means a module has just been inserted. Any flag set while all three levels read low means the cage has reached a clean state, and the link can be restarted.

Top module: `sfp_cage_monitor`

## Requirements
- R1: The status word carries the present synchronised level of receive loss in bit 0, transmit fault in bit 1 and module absent in bit 2.
- R2: The status word carries the change flag of receive loss in bit 3, of transmit fault in bit 4 and of module absent in bit 5.
- R3: A pin level that changes before clock edge k is visible in the status level bits from edge k+1 on, after two synchroniser stages, and not earlier.
- R4: A rising or a falling change of a synchronised level sets the matching change flag, and the flag is visible from edge k+2 for a pin change before edge k.
- R5: A read strobe that is high at a clock edge clears every change flag at that edge, unless R6 applies. The status word sampled while the strobe is high still shows the flags as they stood before the clear.
- R6: When a change of a level is detected at the same edge at which a read strobe clears the flags, the flag of that level stays set.
- R7: The interrupt output is high exactly when at least one change flag is set.
- R8: After reset, all change flags are 0 and every synchroniser stage holds receive loss 1, transmit fault 0 and module absent 1, so the status word reads 0x05 with the interrupt low.
- R9: A change flag stays set with no read, even if its pin returns to its earlier level, so a short pulse still leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_loss_pin | input | 1 | Raw receive loss-of-signal pin, asynchronous |
| tx_fault_pin | input | 1 | Raw transmit fault pin, asynchronous |
| mod_absent_pin | input | 1 | Raw module-absent pin, high when the cage is empty |
| rd_strobe | input | 1 | One-cycle strobe marking a read of the status word |
| status | output | 6 | Bits 2:0 present levels, bits 5:3 sticky change flags |
| irq | output | 1 | High while any change flag is set |

## Verification
Several pin patterns are applied:
- Module insertion, which makes two pins fall together. This separates the flag positions from the level positions.
- A short transmit-fault pulse that returns to its old level before any read. This shows that a flag is sticky, as opposed to one that only follows the present level.
- Module removal, and then two pins rising at once. These show that each pin sets only its own flag, and that a clean read empties the flags.

Back-to-back reads, taken one cycle apart after a single pin change, pin down the exact latency of the level bits and of the flag bits. A change placed on the clearing edge of a read checks that the new change survives the clear, while a read with no coinciding change clears the word completely.

// File: rtl/sfp_cage_monitor.sv
module sfp_cage_monitor #(
  parameter int         SYNC_STAGES  = 2,
  parameter logic [2:0] RESET_LEVELS = 3'b101
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_loss_pin,
  input  logic       tx_fault_pin,
  input  logic       mod_absent_pin,
  input  logic       rd_strobe,
  output logic [5:0] status,
  output logic       irq
);

  localparam int NSIG = 3;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] sync_q [SYNC_STAGES];
  logic [NSIG-1:0] level;
  logic [NSIG-1:0] prev_q;
  logic [NSIG-1:0] chg;
  logic [NSIG-1:0] flag_q;

  assign raw = {mod_absent_pin, tx_fault_pin, rx_loss_pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= RESET_LEVELS;
    else        sync_q[0] <= raw;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= RESET_LEVELS;
      else        sync_q[s] <= sync_q[s-1];
    end
  end

  assign level = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RESET_LEVELS;
    else        prev_q <= level;
  end

  assign chg = level ^ prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_q <= '0;
    else if (rd_strobe) flag_q <= chg;
    else                flag_q <= flag_q | chg;
  end

  assign status = {flag_q, level};
  assign irq    = |flag_q;

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (chg != '0) |=> ((status[5:3] & $past(chg)) == $past(chg)));  // R4

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> ((status[5:3] & ~$past(chg)) == '0));  // R5

  AST_EDGE_BEATS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && chg != '0) |=> ((status[5:3] & $past(chg)) != '0));  // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> ((status[5:3] & $past(status[5:3])) == $past(status[5:3])));  // R9

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(chg) != '0));  // R7

  AST_NO_EDGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (chg == '0 && !rd_strobe) |=> $stable(status[5:3]));  // R9

endmodule

// File: tb/test_sfp_cage_monitor.sv
module test_sfp_cage_monitor;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       rx_loss_pin = 1, tx_fault_pin = 0, mod_absent_pin = 1;
  logic       rd_strobe = 0;
  logic [5:0] status;
  logic       irq;

  int total = 0, bad = 0;
  logic [6:0] exp_q [$];
  string      tag_q [$];
  bit         done = 0;

  always #4 clk = ~clk;

  sfp_cage_monitor i_sfp_cage_monitor (
    .clk(clk), .rst_n(rst_n),
    .rx_loss_pin(rx_loss_pin), .tx_fault_pin(tx_fault_pin),
    .mod_absent_pin(mod_absent_pin), .rd_strobe(rd_strobe),
    .status(status), .irq(irq));

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic rd(input logic [5:0] st, input string tag);
    exp_q.push_back({|st[5:3], st});
    tag_q.push_back(tag);
    rd_strobe = 1;
    tick(1);
    rd_strobe = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_strobe) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard: read with no expected item");
      end else begin
        logic [6:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (status !== e[5:0]) begin
          bad++;
          $display("FAIL %s status: actual=%h expected=%h", t, status, e[5:0]);
        end
        total++;
        if (irq !== e[6]) begin
          bad++;
          $display("FAIL R7 irq (%s): actual=%b expected=%b", t, irq, e[6]);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst_n = 1;
    tick(2);
    rd(6'h05, "R8");
    // insertion: rx loss and absent fall together
    rx_loss_pin = 0; mod_absent_pin = 0;
    tick(4);
    rd(6'h28, "R2");
    rd(6'h00, "R5");
    // short transmit-fault pulse, no read in between
    tx_fault_pin = 1; tick(3); tx_fault_pin = 0;
    tick(5);
    rd(6'h10, "R9");
    rd(6'h00, "R5");
    // removal
    mod_absent_pin = 1;
    tick(4);
    rd(6'h24, "R1");
    rd(6'h04, "R5");
    // two pins rise together
    rx_loss_pin = 1; tx_fault_pin = 1;
    tick(4);
    rd(6'h1F, "R2");
    rd(6'h07, "R1");
    // latency: change, then back-to-back reads
    rx_loss_pin = 0;
    tick(1);
    rd(6'h07, "R3");
    rd(6'h06, "R3");
    rd(6'h0E, "R4");
    rd(6'h06, "R5");
    // change coinciding with a clearing read
    rx_loss_pin = 1;
    tick(4);
    rx_loss_pin = 0;
    tick(2);
    rd(6'h0E, "R6");
    rd(6'h0E, "R6");
    rd(6'h06, "R5");
    tick(2);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule